// File: doc/BRIEF.md
# PLL Power Sequencing Controller

This block drives the digital controls of a clock multiplier through bring-up and shut-down. When an enable request arrives, it first checks that the reference rate and the requested divider give a legal VCO rate. It then steps through the set-up in a fixed order, one control change per clock: release the soft reset, select the good-reference bandwidth code, load the feedback divider, and power the multiplier up. After that it waits a bounded time for the lock indication.

A disable request powers the multiplier down and then puts it back into soft reset. The power-down control bit has a polarity set by a parameter. The enabled state is reported from that bit. The multiplied VCO rate, in kHz, is computed from the programmed divider and the latched reference rate.

A busy flag covers every sequence, and requests that arrive while busy are dropped. Two sticky flags record a lock timeout and a rejected request.

Top module: `pll_pwr_seq`

## Requirements
- R1: The edge k that accepts an enable request starts the set-up sequence. At edge k+1, soft_rst_no goes high. At edge k+2, bw_sel_o becomes 0. At edge k+3, ndiv_o takes the requested divider. At edge k+4, the power-down bit moves to the powered level. No two of these changes happen at the same edge.
- R2: bw_sel_o is a 2-bit code: 0 good reference, 1 very bad, 2 bad, 3 very good. It resets to 3, and every enable sequence writes 0.
- R3: With PDN_POL=1 the multiplier is powered when pdn_o is 0. With PDN_POL=0 it is powered when pdn_o is 1. enabled_o is high exactly while pdn_o is at the powered level.
- R4: After power-up the controller waits for lock_i. If lock_i is high after edge j, busy_o falls at edge j+1. If no lock is seen within TMO cycles (CLK_KHZ*TIMEOUT_US/1000) after power-up, lock_err_o is set and busy_o falls at edge k+4+TMO. The multiplier is left powered.
- R5: The edge k that accepts a disable request starts the shut-down sequence. The power-down bit moves to the unpowered level at edge k+1, while the reset is still released. soft_rst_no falls at edge k+2, and busy_o falls at the same edge.
- R6: vco_khz_o equals the latched reference in kHz times (ndiv_o + 16). It changes only while busy_o is high.
- R7: An enable request is rejected if ref_khz_i > 40000, or if ref_khz_i*(ndiv_i+16) is outside 384000..660000. A rejected request sets cfg_err_o at edge k and starts no sequence: busy_o stays low and no control output moves.
- R8: busy_o is high from edge k until the sequence ends. Enable and disable requests that arrive while busy_o is high are ignored.
- R9: Any enable request seen while idle clears lock_err_o. An accepted request clears cfg_err_o.
- R10: After reset: soft_rst_no=0, power-down bit at the unpowered level, bw_sel_o=3, ndiv_o=0, and busy_o, enabled_o, lock_err_o and cfg_err_o all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_req_i | input | 1 | Enable request, one-cycle pulse |
| dis_req_i | input | 1 | Disable request, one-cycle pulse |
| ndiv_i | input | DIV_W | Divider code for the enable request |
| ref_khz_i | input | REF_W | Reference rate in kHz |
| lock_i | input | 1 | Lock indication from the multiplier |
| soft_rst_no | output | 1 | Soft reset to the multiplier, low = held in reset |
| bw_sel_o | output | 2 | Reference bandwidth code |
| ndiv_o | output | DIV_W | Programmed divider code |
| pdn_o | output | 1 | Power-down control, polarity set by PDN_POL |
| busy_o | output | 1 | A sequence is running |
| enabled_o | output | 1 | Multiplier powered |
| lock_err_o | output | 1 | Sticky lock timeout |
| cfg_err_o | output | 1 | Sticky rejected request |
| vco_khz_o | output | VCO_W | Multiplied VCO rate in kHz |

## Verification
Each request is driven on a falling edge, so the rising edge that captures it is edge k. Every control output is registered, so its change becomes visible after edges k+1 through k+4 for enable, and after k+1 and k+2 for disable. The bench samples each output on the falling edge just after the edge where it is due, and also checks the output one edge earlier to confirm it has not changed too soon. The lock model in the bench raises lock_i a known number of cycles after power-up. This fixes the edge where busy_o must fall, both for a lock and for a timeout. A reject is due at edge k itself.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REL, ST_BW, ST_DIV, ST_PWR, ST_WAIT, ST_PDN, ST_RST
  } seq_st_e;

  localparam logic [1:0] BW_GOOD  = 2'd0;
  localparam logic [1:0] BW_VBAD  = 2'd1;
  localparam logic [1:0] BW_BAD   = 2'd2;
  localparam logic [1:0] BW_VGOOD = 2'd3;

  localparam int DIV_OFFSET = 16;
endpackage

// File: rtl/pll_vco_calc.sv
module pll_vco_calc #(
  parameter int REF_W = 16,
  parameter int DIV_W = 3,
  parameter int VCO_W = 21
) (
  input  logic [REF_W-1:0] ref_khz_i,
  input  logic [DIV_W-1:0] div_code_i,
  output logic [VCO_W-1:0] vco_khz_o
);
  import pll_seq_pkg::*;
  logic [VCO_W-1:0] mult;
  always_comb begin
    mult      = VCO_W'(div_code_i) + VCO_W'(DIV_OFFSET);
    vco_khz_o = VCO_W'(ref_khz_i) * mult;
  end
endmodule

// File: rtl/pll_req_check.sv
module pll_req_check #(
  parameter int REF_W   = 16,
  parameter int VCO_W   = 21,
  parameter int REF_MAX = 40000,
  parameter int VCO_MIN = 384000,
  parameter int VCO_MAX = 660000
) (
  input  logic [REF_W-1:0] ref_khz_i,
  input  logic [VCO_W-1:0] vco_khz_i,
  output logic             ok_o
);
  always_comb begin
    ok_o = (32'(ref_khz_i) <= REF_MAX) &&
           (32'(vco_khz_i) >= VCO_MIN) &&
           (32'(vco_khz_i) <= VCO_MAX);
  end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int TMO_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign expire_o = run_i && (cnt_q == CNT_W'(TMO_CYC - 1));
endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq #(
  parameter int   REF_W      = 16,
  parameter int   DIV_W      = 3,
  parameter bit   PDN_POL    = 1'b1,
  parameter bit   HAS_RST    = 1'b1,
  parameter int   CLK_KHZ    = 50000,
  parameter int   TIMEOUT_US = 10000,
  parameter int   REF_MAX    = 40000,
  parameter int   VCO_MIN    = 384000,
  parameter int   VCO_MAX    = 660000,
  localparam int  VCO_W      = REF_W + $clog2((2**DIV_W) + 16)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_req_i,
  input  logic             dis_req_i,
  input  logic [DIV_W-1:0] ndiv_i,
  input  logic [REF_W-1:0] ref_khz_i,
  input  logic             lock_i,
  output logic             soft_rst_no,
  output logic [1:0]       bw_sel_o,
  output logic [DIV_W-1:0] ndiv_o,
  output logic             pdn_o,
  output logic             busy_o,
  output logic             enabled_o,
  output logic             lock_err_o,
  output logic             cfg_err_o,
  output logic [VCO_W-1:0] vco_khz_o
);
  import pll_seq_pkg::*;

  localparam int TMO_CYC = (CLK_KHZ * TIMEOUT_US) / 1000;

  seq_st_e          st_q;
  logic             rel_q, pwr_q, lock_err_q, cfg_err_q;
  logic [1:0]       bw_q;
  logic [DIV_W-1:0] ndiv_q, ndiv_req_q;
  logic [REF_W-1:0] ref_q;
  logic [VCO_W-1:0] req_vco;
  logic             req_ok, tmo_hit;

  pll_vco_calc #(.REF_W(REF_W), .DIV_W(DIV_W), .VCO_W(VCO_W)) u_req_vco (
    .ref_khz_i (ref_khz_i),
    .div_code_i(ndiv_i),
    .vco_khz_o (req_vco)
  );

  pll_req_check #(
    .REF_W(REF_W), .VCO_W(VCO_W), .REF_MAX(REF_MAX),
    .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX)
  ) u_chk_req (
    .ref_khz_i(ref_khz_i),
    .vco_khz_i(req_vco),
    .ok_o     (req_ok)
  );

  pll_lock_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (st_q == ST_WAIT && !lock_i),
    .expire_o(tmo_hit)
  );

  // rate of the programmed setting
  pll_vco_calc #(.REF_W(REF_W), .DIV_W(DIV_W), .VCO_W(VCO_W)) u_out_vco (
    .ref_khz_i (ref_q),
    .div_code_i(ndiv_q),
    .vco_khz_o (vco_khz_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rel_q      <= 1'b0;
      pwr_q      <= 1'b0;
      bw_q       <= BW_VGOOD;
      ndiv_q     <= '0;
      ndiv_req_q <= '0;
      ref_q      <= '0;
      lock_err_q <= 1'b0;
      cfg_err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (en_req_i) begin
            lock_err_q <= 1'b0;
            if (req_ok) begin
              cfg_err_q  <= 1'b0;
              ref_q      <= ref_khz_i;
              ndiv_req_q <= ndiv_i;
              st_q       <= ST_REL;
            end else begin
              cfg_err_q  <= 1'b1;
            end
          end else if (dis_req_i) begin
            st_q <= ST_PDN;
          end
        end
        ST_REL: begin
          rel_q <= 1'b1;
          st_q  <= ST_BW;
        end
        ST_BW: begin
          bw_q <= BW_GOOD;
          st_q <= ST_DIV;
        end
        ST_DIV: begin
          ndiv_q <= ndiv_req_q;
          st_q   <= ST_PWR;
        end
        ST_PWR: begin
          pwr_q <= 1'b1;
          st_q  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (lock_i) begin
            st_q <= ST_IDLE;
          end else if (tmo_hit) begin
            lock_err_q <= 1'b1;
            st_q       <= ST_IDLE;
          end
        end
        ST_PDN: begin
          pwr_q <= 1'b0;
          st_q  <= ST_RST;
        end
        ST_RST: begin
          rel_q <= 1'b0;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  generate
    if (HAS_RST) begin : g_rst
      assign soft_rst_no = rel_q;
    end else begin : g_no_rst
      assign soft_rst_no = 1'b1;
    end
  endgenerate

  assign pdn_o      = pwr_q ? ~PDN_POL : PDN_POL;
  assign enabled_o  = pwr_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign bw_sel_o   = bw_q;
  assign ndiv_o     = ndiv_q;
  assign lock_err_o = lock_err_q;
  assign cfg_err_o  = cfg_err_q;
endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk #(
  parameter int VCO_W   = 21,
  parameter bit HAS_RST = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_no,
  input logic [1:0]       bw_sel_o,
  input logic             pdn_o,
  input logic             busy_o,
  input logic             enabled_o,
  input logic             lock_err_o,
  input logic             cfg_err_o,
  input logic [VCO_W-1:0] vco_khz_o
);
  assert_bw_after_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_no) |=> (bw_sel_o == 2'd0));

  assert_power_after_bw_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enabled_o) |-> (bw_sel_o == 2'd0) && soft_rst_no);

  assert_timeout_ends_seq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_err_o) |-> $past(busy_o) && !busy_o && enabled_o);

  generate
    if (HAS_RST) begin : g_rst_chk
      assert_reset_after_pdn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(enabled_o) |-> soft_rst_no ##1 !soft_rst_no);
    end
  endgenerate

  assert_vco_moves_in_seq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vco_khz_o) |-> busy_o);

  assert_reject_no_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> !busy_o && $stable(pdn_o));
endmodule

bind pll_pwr_seq pll_pwr_seq_chk #(.VCO_W(VCO_W), .HAS_RST(HAS_RST)) u_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_no(soft_rst_no),
  .bw_sel_o   (bw_sel_o),
  .pdn_o      (pdn_o),
  .busy_o     (busy_o),
  .enabled_o  (enabled_o),
  .lock_err_o (lock_err_o),
  .cfg_err_o  (cfg_err_o),
  .vco_khz_o  (vco_khz_o)
);

// File: tb/pll_pwr_seq_tb_top.sv
module pll_pwr_seq_tb_top;
  localparam int TMO = 1000; // 50000 kHz * 20 us / 1000

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_req = 1'b0, dis_req = 1'b0;
  logic [2:0]  ndiv = '0;
  logic [15:0] rk = '0;
  logic        lock;
  logic        srst_n, pdn, busy, enab, lerr, cerr;
  logic [1:0]  bw;
  logic [2:0]  ndiv_q;
  logic [20:0] vco;
  logic        srst_n_b, pdn_b, busy_b, enab_b, lerr_b, cerr_b;
  logic [1:0]  bw_b;
  logic [2:0]  ndiv_b;
  logic [20:0] vco_b;

  int checks = 0, errors = 0;
  int lock_dly = 0;
  int lk_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!pdn) lk_cnt <= lk_cnt + 1;
    else      lk_cnt <= 0;
  end
  assign lock = !pdn && (lk_cnt >= lock_dly);

  pll_pwr_seq #(.CLK_KHZ(50000), .TIMEOUT_US(20)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en_req), .dis_req_i(dis_req),
    .ndiv_i(ndiv), .ref_khz_i(rk), .lock_i(lock),
    .soft_rst_no(srst_n), .bw_sel_o(bw), .ndiv_o(ndiv_q), .pdn_o(pdn),
    .busy_o(busy), .enabled_o(enab), .lock_err_o(lerr), .cfg_err_o(cerr),
    .vco_khz_o(vco)
  );

  pll_pwr_seq #(.CLK_KHZ(50000), .TIMEOUT_US(20), .PDN_POL(1'b0)) dut_p0_i (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en_req), .dis_req_i(dis_req),
    .ndiv_i(ndiv), .ref_khz_i(rk), .lock_i(lock),
    .soft_rst_no(srst_n_b), .bw_sel_o(bw_b), .ndiv_o(ndiv_b), .pdn_o(pdn_b),
    .busy_o(busy_b), .enabled_o(enab_b), .lock_err_o(lerr_b), .cfg_err_o(cerr_b),
    .vco_khz_o(vco_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic bit legal(input int r, input int d);
    int v;
    v = r * (d + 16);
    return (r <= 40000) && (v >= 384000) && (v <= 660000);
  endfunction

  task automatic pulse_en(input int r, input int d);
    @(negedge clk);
    rk = 16'(r); ndiv = 3'(d); en_req = 1'b1;
    @(negedge clk);
    en_req = 1'b0;
  endtask

  // enable from the disabled state, lock after dly cycles
  task automatic do_enable(input int r, input int d, input int dly);
    bit   ok;
    logic pdn_before;
    logic [2:0] nd_before;
    ok = legal(r, d);
    lock_dly = dly;
    pdn_before = pdn;
    nd_before = ndiv_q;
    pulse_en(r, d); // after edge k
    if (!ok) begin
      chk(cerr == 1'b1 && busy == 1'b0, "R7 reject flag", int'(cerr), 1);
      chk(pdn == pdn_before && srst_n == 1'b0, "R7 no control change", int'(pdn), int'(pdn_before));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && pdn == pdn_before && ndiv_q == nd_before, "R7 still idle",
          int'(busy), 0);
      return;
    end
    chk(busy == 1'b1 && srst_n == 1'b0, "R8 busy at k, reset held", int'(srst_n), 0);
    chk(cerr == 1'b0, "R9 accepted clears cfg_err", int'(cerr), 0);
    @(negedge clk); // k+1
    chk(srst_n == 1'b1 && ndiv_q == nd_before, "R1 reset released first", int'(srst_n), 1);
    @(negedge clk); // k+2
    chk(bw == 2'd0 && ndiv_q == nd_before, "R1 bandwidth before divider", int'(ndiv_q), int'(nd_before));
    @(negedge clk); // k+3
    chk(ndiv_q == 3'(d) && pdn == 1'b1, "R1 divider before power", int'(ndiv_q), d);
    @(negedge clk); // k+4
    chk(pdn == 1'b0 && enab == 1'b1, "R3 powered when pdn low", int'(pdn), 0);
    chk(pdn_b == 1'b1 && enab_b == 1'b1, "R3 inverse polarity powered high", int'(pdn_b), 1);
    repeat (dly) @(negedge clk); // k+4+dly
    chk(busy == 1'b1, "R4 still waiting for lock", int'(busy), 1);
    @(negedge clk); // k+5+dly
    chk(busy == 1'b0 && lerr == 1'b0, "R4 done one edge after lock", int'(busy), 0);
    chk(int'(vco) == r * (d + 16), "R6 vco rate", int'(vco), r * (d + 16));
  endtask

  task automatic do_disable();
    @(negedge clk);
    dis_req = 1'b1;
    @(negedge clk); // k
    dis_req = 1'b0;
    chk(busy == 1'b1 && enab == 1'b1, "R8 busy in shutdown", int'(busy), 1);
    @(negedge clk); // k+1
    chk(enab == 1'b0 && pdn == 1'b1 && srst_n == 1'b1, "R5 power down first", int'(srst_n), 1);
    chk(pdn_b == 1'b0, "R3 inverse polarity unpowered low", int'(pdn_b), 0);
    @(negedge clk); // k+2
    chk(srst_n == 1'b0 && busy == 1'b0, "R5 reset after power down", int'(srst_n), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    int refs[6] = '{20000, 23999, 24000, 30000, 40000, 40001};
    repeat (3) @(negedge clk);
    chk(srst_n == 0 && pdn == 1 && bw == 2'd3 && ndiv_q == 0, "R10 reset controls", int'(bw), 3);
    chk(busy == 0 && enab == 0 && lerr == 0 && cerr == 0, "R10 reset flags", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // first run shows bandwidth leaving its reset code
    do_enable(30000, 5, 2);
    chk(bw == 2'd0, "R2 good reference code", int'(bw), 0);
    do_disable();
    for (int i = 0; i < 6; i++) begin
      for (int d = 0; d < 8; d++) begin
        do_enable(refs[i], d, 1 + (d % 4));
        if (enab) do_disable();
      end
    end
    // requests during a sequence are dropped
    lock_dly = 8;
    pulse_en(24000, 2);
    repeat (6) @(negedge clk);
    dis_req = 1'b1;
    @(negedge clk);
    dis_req = 1'b0;
    repeat (10) @(negedge clk);
    chk(enab == 1'b1 && busy == 1'b0, "R8 disable ignored while busy", int'(enab), 1);
    dis_req = 1'b1;
    @(negedge clk);
    dis_req = 1'b0;
    en_req = 1'b1; rk = 16'd24000; ndiv = 3'd3;
    @(negedge clk);
    en_req = 1'b0;
    @(negedge clk);
    chk(enab == 1'b0, "R8 enable ignored during shutdown", int'(enab), 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && enab == 1'b0 && srst_n == 1'b0, "R8 stays off", int'(busy), 0);
    // lock timeout
    lock_dly = 1000000;
    pulse_en(24000, 1); // after k
    repeat (3 + TMO) @(negedge clk); // k+3+TMO
    chk(busy == 1'b1 && lerr == 1'b0, "R4 not yet timed out", int'(busy), 1);
    @(negedge clk); // k+4+TMO
    chk(busy == 1'b0 && lerr == 1'b1, "R4 timeout flag", int'(lerr), 1);
    chk(enab == 1'b1, "R4 left powered after timeout", int'(enab), 1);
    // rejected request clears lock_err, sets cfg_err
    pulse_en(40001, 0);
    chk(lerr == 1'b0 && cerr == 1'b1, "R9 request clears lock_err", int'(lerr), 0);
    do_disable();
    lock_dly = 0;
    do_enable(30000, 0, 0);
    chk(cerr == 1'b0, "R9 accepted clears cfg_err", int'(cerr), 0);
    do_disable();
    summary();
  end
endmodule